// File: doc/BRIEF.md
# Processor sleep and pause controller

This block decides when a simple in-order core stops and restarts. A sleep, hibernate or suspend instruction strobe, or a reset-mode field set to binary 10, asks the core to go to sleep. A level-sensitive pause input asks it to stop and later continue where it stopped. In every case the block raises a pipeline-halt signal at once. The matching status flag or acknowledge rises only when the count of outstanding bus transactions has reached zero.

Two wakeup request bits bring the core out of sleep. Each bit goes through an optional two-flop synchronizer, chosen per bit by a parameter, and the bits are ignored unless the core is asleep. A debug-side access request produces a one-cycle strobe. That strobe asks external logic to drive wakeup while the core sleeps, or to release pause while it is paused.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, halt, all three sleep flags, pause acknowledge and both debug strobes are 0, and the controller is running.
- R2: A sleep request is a sleep, hibernate or suspend strobe, or rmode equal to 2'b10 (other rmode values do nothing); halt rises on the clock edge that samples the request.
- R3: A sleep flag rises only on an edge at which the outstanding count sampled is zero; while the count is nonzero, halt stays 1 and all flags stay 0.
- R4: The flavour is reported on its own flag (sleep_o, hibernate_o, suspend_o); at most one flag is set; simultaneous strobes resolve sleep over hibernate over suspend; rmode 2'b10 reports plain sleep.
- R5: While asleep, a wakeup bit equal to 1 (either or both) returns the block to running; halt and all flags clear on that edge.
- R6: Wakeup bits that arrive while the block is not asleep are ignored and are not remembered for a later sleep.
- R7: With ASYNC_WAKE bit i set to 1, wakeup[i] passes two flops, so the block leaves sleep on the third edge after it is first sampled; with bit i set to 0, it leaves sleep on the first edge.
- R8: From running, pause_req raises halt on the next edge; pause_ack rises on the first edge at which the outstanding count sampled is zero.
- R9: When pause_req falls, during drain or while paused, halt and pause_ack drop on the next edge and execution resumes.
- R10: A sleep request and pause_req in the same cycle enter sleep; pause_ack is never 1 while a sleep flag is 1.
- R11: A rising edge on dbg_access produces a one-cycle dbg_wake_req pulse if the block is asleep, or a one-cycle dbg_cont_req pulse if it is paused, on the next edge; neither pulses while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_insn | input | 1 | One-cycle strobe from a plain sleep instruction |
| hibernate_insn | input | 1 | One-cycle strobe from a hibernate instruction |
| suspend_insn | input | 1 | One-cycle strobe from a suspend instruction |
| rmode | input | 2 | Reset-mode field; 2'b10 requests plain sleep |
| wakeup | input | 2 | Wakeup request bits, either may be asynchronous |
| pause_req | input | 1 | Level pause request |
| outstanding | input | OUT_W | Count of bus transactions in flight |
| dbg_access | input | 1 | Debug module wants access |
| halt | output | 1 | Pipeline must not issue |
| sleep_o | output | 1 | Asleep after a plain sleep request, bus drained |
| hibernate_o | output | 1 | Asleep after a hibernate strobe, bus drained |
| suspend_o | output | 1 | Asleep after a suspend strobe, bus drained |
| pause_ack | output | 1 | Paused, bus drained |
| dbg_wake_req | output | 1 | One-cycle request to assert wakeup |
| dbg_cont_req | output | 1 | One-cycle request to clear pause |

## Verification
A vector table drives each way of requesting a stop: each single strobe, rmode 10 against a non-sleep rmode value, pause alone, pause together with a strobe, and two strobes at once. These show that each flavour reaches its own flag and that the priorities hold. Directed runs hold the outstanding count nonzero, to separate the immediate halt from the delayed flag, and release pause while the bus is still draining. Wakeups are sent on the direct bit and on the synchronized bit, which distinguishes one-edge from three-edge latency. A wakeup sent while running must leave no trace, and a debug request is raised in each of the three states.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_DRAIN_SLP = 3'd1,
        ST_SLEEP     = 3'd2,
        ST_DRAIN_PAU = 3'd3,
        ST_PAUSE     = 3'd4
    } ctl_state_e;

    typedef enum logic [1:0] {
        FLV_NONE  = 2'd0,
        FLV_PLAIN = 2'd1,
        FLV_HIB   = 2'd2,
        FLV_SUS   = 2'd3
    } flavour_e;

    typedef struct packed {
        logic     valid;
        flavour_e flv;
    } slp_req_t;

    typedef struct packed {
        logic plain;
        logic hib;
        logic sus;
    } slp_flags_t;

    localparam logic [1:0] RMODE_SLEEP = 2'b10;
    localparam int         WAKE_BITS   = 2;

    // Priority: plain sleep (strobe or rmode) over hibernate over suspend.
    function automatic slp_req_t decode_req(input logic s, input logic h,
                                            input logic u, input logic [1:0] rm);
        slp_req_t r;
        r.valid = 1'b1;
        if (s || rm == RMODE_SLEEP) r.flv = FLV_PLAIN;
        else if (h)                 r.flv = FLV_HIB;
        else if (u)                 r.flv = FLV_SUS;
        else begin
            r.valid = 1'b0;
            r.flv   = FLV_NONE;
        end
        return r;
    endfunction

    function automatic slp_flags_t flags_of(input flavour_e f);
        slp_flags_t o;
        o.plain = (f == FLV_PLAIN);
        o.hib   = (f == FLV_HIB);
        o.sus   = (f == FLV_SUS);
        return o;
    endfunction

endpackage

// File: rtl/slp_wake_sync.sv
module slp_wake_sync #(
    parameter int          NBITS = 2,
    parameter logic [NBITS-1:0] ASYNC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] raw,
    output logic [NBITS-1:0] synced
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (ASYNC[i]) begin : g_chain
            logic st1, st2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    st1 <= 1'b0;
                    st2 <= 1'b0;
                end else begin
                    st1 <= raw[i];
                    st2 <= st1;
                end
            end
            assign synced[i] = st2;

            // R7: an output rise must have come through the first stage
            assert_chain_order_R7: assert property (@(posedge clk) disable iff (rst)
                $rose(st2) |-> $past(st1));
        end else begin : g_direct
            assign synced[i] = raw[i];
        end
    end
endmodule

// File: rtl/slp_core_fsm.sv
module slp_core_fsm
    import slp_pkg::*;
#(
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  slp_req_t         req,
    input  logic             pause_req,
    input  logic [OUT_W-1:0] outstanding,
    input  logic             wake_any,
    output ctl_state_e       state_o,
    output slp_flags_t       flags,
    output logic             halt,
    output logic             pause_ack
);
    ctl_state_e state_q, state_d;
    flavour_e   flv_q, flv_d;
    logic       drained;

    assign drained = (outstanding == '0);

    always_comb begin
        state_d = state_q;
        flv_d   = flv_q;
        unique case (state_q)
            ST_RUN: begin
                if (req.valid) begin
                    state_d = ST_DRAIN_SLP;
                    flv_d   = req.flv;
                end else if (pause_req) begin
                    state_d = ST_DRAIN_PAU;
                end
            end
            ST_DRAIN_SLP: if (drained) state_d = ST_SLEEP;
            ST_SLEEP: begin
                if (wake_any) begin
                    state_d = ST_RUN;
                    flv_d   = FLV_NONE;
                end
            end
            ST_DRAIN_PAU: begin
                if (!pause_req)   state_d = ST_RUN;
                else if (drained) state_d = ST_PAUSE;
            end
            ST_PAUSE: if (!pause_req) state_d = ST_RUN;
            default: begin
                state_d = ST_RUN;
                flv_d   = FLV_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            flv_q   <= FLV_NONE;
        end else begin
            state_q <= state_d;
            flv_q   <= flv_d;
        end
    end

    assign state_o   = state_q;
    assign halt      = (state_q != ST_RUN);
    assign pause_ack = (state_q == ST_PAUSE);
    always_comb begin
        flags = '0;
        if (state_q == ST_SLEEP) flags = flags_of(flv_q);
    end

    assert_flag_after_drain_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(|flags) |-> $past(outstanding) == '0);
    assert_one_status_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags, pause_ack}));
    assert_flag_implies_halt_R2: assert property (@(posedge clk) disable iff (rst)
        (|flags) |-> halt);
    assert_wake_leaves_R5: assert property (@(posedge clk) disable iff (rst)
        ((|flags) && wake_any) |=> !halt);
    assert_ack_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pause_ack) |-> $past(outstanding) == '0);
    assert_ack_excl_sleep_R10: assert property (@(posedge clk) disable iff (rst)
        pause_ack |-> !(|flags));
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (pause_ack && !pause_req) |=> !halt);
endmodule

// File: rtl/slp_dbg_req.sv
module slp_dbg_req (
    input  logic clk,
    input  logic rst,
    input  logic dbg_access,
    input  logic in_sleep,
    input  logic in_pause,
    output logic wake_req,
    output logic cont_req
);
    logic dbg_q;
    logic edge_seen;

    assign edge_seen = dbg_access && !dbg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_q    <= 1'b0;
            wake_req <= 1'b0;
            cont_req <= 1'b0;
        end else begin
            dbg_q    <= dbg_access;
            wake_req <= edge_seen && in_sleep;
            cont_req <= edge_seen && in_pause;
        end
    end

    assert_strobe_short_R11: assert property (@(posedge clk) disable iff (rst)
        (wake_req || cont_req) |=> !(wake_req || cont_req));
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(wake_req && cont_req));
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int         OUT_W      = 4,
    parameter logic [1:0] ASYNC_WAKE = 2'b01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_insn,
    input  logic             hibernate_insn,
    input  logic             suspend_insn,
    input  logic [1:0]       rmode,
    input  logic [1:0]       wakeup,
    input  logic             pause_req,
    input  logic [OUT_W-1:0] outstanding,
    input  logic             dbg_access,
    output logic             halt,
    output logic             sleep_o,
    output logic             hibernate_o,
    output logic             suspend_o,
    output logic             pause_ack,
    output logic             dbg_wake_req,
    output logic             dbg_cont_req
);
    logic [WAKE_BITS-1:0] wake_s;
    slp_req_t             req;
    ctl_state_e           state;
    slp_flags_t           flags;

    assign req = decode_req(sleep_insn, hibernate_insn, suspend_insn, rmode);

    slp_wake_sync #(.NBITS(WAKE_BITS), .ASYNC(ASYNC_WAKE)) u_sync (
        .clk(clk), .rst(rst), .raw(wakeup), .synced(wake_s)
    );

    slp_core_fsm #(.OUT_W(OUT_W)) u_fsm (
        .clk(clk), .rst(rst), .req(req), .pause_req(pause_req),
        .outstanding(outstanding), .wake_any(|wake_s),
        .state_o(state), .flags(flags), .halt(halt), .pause_ack(pause_ack)
    );

    slp_dbg_req u_dbg (
        .clk(clk), .rst(rst), .dbg_access(dbg_access),
        .in_sleep(state == ST_SLEEP), .in_pause(state == ST_PAUSE),
        .wake_req(dbg_wake_req), .cont_req(dbg_cont_req)
    );

    assign sleep_o     = flags.plain;
    assign hibernate_o = flags.hib;
    assign suspend_o   = flags.sus;
endmodule

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_insn = 0, hibernate_insn = 0, suspend_insn = 0;
    logic [1:0] rmode = 2'b00;
    logic [1:0] wakeup = 2'b00;
    logic pause_req = 0;
    logic [3:0] outstanding = 4'd0;
    logic dbg_access = 0;
    logic halt, sleep_o, hibernate_o, suspend_o, pause_ack, dbg_wake_req, dbg_cont_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    slp_ctrl #(.OUT_W(4), .ASYNC_WAKE(2'b01)) dut (
        .clk(clk), .rst(rst), .sleep_insn(sleep_insn), .hibernate_insn(hibernate_insn),
        .suspend_insn(suspend_insn), .rmode(rmode), .wakeup(wakeup), .pause_req(pause_req),
        .outstanding(outstanding), .dbg_access(dbg_access), .halt(halt), .sleep_o(sleep_o),
        .hibernate_o(hibernate_o), .suspend_o(suspend_o), .pause_ack(pause_ack),
        .dbg_wake_req(dbg_wake_req), .dbg_cont_req(dbg_cont_req)
    );

    // observed = {halt, sleep, hibernate, suspend, ack, dbg_wake, dbg_cont}
    function automatic logic [6:0] obs();
        return {halt, sleep_o, hibernate_o, suspend_o, pause_ack, dbg_wake_req, dbg_cont_req};
    endfunction

    task automatic chk(input string req, input logic [6:0] exp);
        checks++;
        if (obs() !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, obs(), exp);
        end
    endtask

    // one posedge, then move to the following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // entry: {sleep, hib, sus, rmode[1:0], pause, exp_sleep, exp_hib, exp_sus, exp_ack}
    localparam logic [9:0] VEC [8] = '{
        10'b100_00_0_1000,   // R2 R4 plain sleep strobe
        10'b010_00_0_0100,   // R4 hibernate
        10'b001_00_0_0010,   // R4 suspend
        10'b000_10_0_1000,   // R2 rmode 10 -> plain sleep
        10'b000_01_0_0000,   // R2 rmode 01 -> nothing
        10'b000_00_1_0001,   // R8 pause
        10'b010_00_1_0100,   // R10 hibernate wins over pause
        10'b111_00_0_1000    // R4 priority sleep > hibernate > suspend
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", 7'b0000000);

        for (int i = 0; i < 8; i++) begin
            logic [9:0] v;
            logic any;
            v = VEC[i];
            any = |v[3:0];
            {sleep_insn, hibernate_insn, suspend_insn} = v[9:7];
            rmode = v[6:5];
            pause_req = v[4];
            step();
            sleep_insn = 0; hibernate_insn = 0; suspend_insn = 0; rmode = 2'b00;
            step();
            chk($sformatf("R2/R4/R8/R10 vector %0d", i), {any, v[3:0], 2'b00});
            pause_req = 0;
            wakeup = 2'b10;
            step();
            wakeup = 2'b00;
            chk($sformatf("R5/R9 release vector %0d", i), 7'b0000000);
            step();
        end

        // R3: drain holds the sleep flag back
        outstanding = 4'd3;
        suspend_insn = 1;
        step();
        suspend_insn = 0;
        chk("R2 halt on request edge", 7'b1000000);
        repeat (3) step();
        chk("R3 flag waits for drain", 7'b1000000);
        outstanding = 4'd0;
        step();
        chk("R3 flag after drain", 7'b1001000);

        // R11: debug wake strobe while asleep
        dbg_access = 1;
        step();
        chk("R11 wake strobe", 7'b1001010);
        step();
        chk("R11 wake strobe one cycle", 7'b1001000);
        dbg_access = 0;

        // R7: synchronized bit 0 takes three edges
        wakeup = 2'b01;
        step();
        wakeup = 2'b00;
        chk("R7 sync edge 1 still asleep", 7'b1001000);
        step();
        chk("R7 sync edge 2 still asleep", 7'b1001000);
        step();
        chk("R7 sync edge 3 running", 7'b0000000);
        repeat (2) step();

        // R6: wakeup while running is not remembered
        wakeup = 2'b11;
        step();
        wakeup = 2'b00;
        repeat (4) step();
        chk("R6 wakeup ignored when running", 7'b0000000);
        hibernate_insn = 1;
        step();
        hibernate_insn = 0;
        step();
        repeat (4) step();
        chk("R6 sleep not cut short", 7'b1010000);
        dbg_access = 1;
        wakeup = 2'b10;
        step();
        wakeup = 2'b00;
        chk("R5 wake with direct bit", 7'b0000010);
        step();
        dbg_access = 0;
        step();
        dbg_access = 1;
        step();
        chk("R11 no strobe while running", 7'b0000000);
        dbg_access = 0;

        // R8: pause waits for drain, R11 continue strobe
        outstanding = 4'd2;
        pause_req = 1;
        step();
        chk("R8 halt before ack", 7'b1000000);
        repeat (2) step();
        chk("R8 ack waits for drain", 7'b1000000);
        outstanding = 4'd0;
        step();
        chk("R8 ack after drain", 7'b1000100);
        wakeup = 2'b10;
        dbg_access = 1;
        step();
        wakeup = 2'b00;
        chk("R6/R11 wakeup ignored, continue strobe", 7'b1000101);
        dbg_access = 0;
        pause_req = 0;
        step();
        chk("R9 resume from pause", 7'b0000000);

        // R9: release during drain
        outstanding = 4'd5;
        pause_req = 1;
        repeat (2) step();
        pause_req = 0;
        step();
        chk("R9 release during drain", 7'b0000000);
        outstanding = 4'd0;

        // R1: reset from a halted state
        sleep_insn = 1;
        step();
        sleep_insn = 0;
        step();
        rst = 1;
        step();
        rst = 0;
        chk("R1 reset clears sleep", 7'b0000000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule